// File: doc/BRIEF.md
# Windowed Watchdog Supervisor with Two-Stage Escalation

This block watches an external microcontroller. After power-on reset it opens a long start-up window that ends only when the controller writes a trigger bit of 1. After that the block runs in windowed mode. In each cycle of that mode the controller must write the opposite of the last accepted trigger value, and the write must land after an early boundary and before a late boundary. A valid write restarts the timing at once. A write that repeats the last accepted value does nothing.

Any failure has four effects. The block issues a fixed-width reset pulse to the controller, forces the gate-drive kill high, increments a consecutive-failure counter and returns to the long window. Failures escalate in two stages. On the eighth consecutive failure the block asks for the supply regulator to be switched off for a timed interval, then restarts. After seven more consecutive failures the block holds the regulator off and requests deepest standby until a wake event arrives.

A regulator undervoltage also restarts the long window. Flash mode suspends the watchdog. A disable bit written while in flash mode keeps the watchdog suspended until the next power-on reset. All ports are plain control and status levels. There is no data stream, so there is no handshake.

Top module: `wdg_supervisor`

## Requirements
- R1: After power-on reset, `mcu_rst`, `gate_kill`, `reg_off` and `stby_req` are 0, `fail_cnt` is 0, and the long window starts with the first clock edge after reset release.
- R2: In the long window, only a write with `wr_trig`=1 ends the window, and a write with `wr_trig`=0 is ignored. If no write of 1 arrives, the edge that sees the window count at LONG_TICKS-1 is a failure.
- R3: In windowed mode, a write whose `wr_trig` differs from the last accepted value is a service when the window count is from EARLY_TICKS to LATE_TICKS-1 inclusive. A service restarts the count at 0, clears `fail_cnt` and clears `gate_kill`.
- R4: In windowed mode, a toggling write while the count is below EARLY_TICKS is a failure.
- R5: In windowed mode, if no toggling write arrives by the edge that sees count LATE_TICKS-1, that edge is a failure.
- R6: In windowed mode, a write equal to the last accepted trigger value has no effect. The count keeps running and no failure occurs.
- R7: Each failure raises `mcu_rst` for exactly PULSE_TICKS cycles, sets `gate_kill`, increments `fail_cnt` and restarts the long window.
- R8: The failure that brings `fail_cnt` to STAGE1_FAILS (8) raises `reg_off` for OFF_TICKS cycles. During that time writes are ignored, and no failure occurs. Afterwards the long window starts afresh.
- R9: The failure that brings `fail_cnt` to STAGE1_FAILS+STAGE2_FAILS (15) raises `stby_req` and `reg_off`, and both stay high until `wake_evt`. `wake_evt` clears both, resets `fail_cnt` to 0 and starts the long window.
- R10: `vdd_uv` restarts the long window from count 0 without counting a failure.
- R11: While `flash_mode` is 1, the watchdog is inactive and no failure occurs. When `flash_mode` returns to 0, the long window starts.
- R12: A write with `wr_dis`=1 while `flash_mode` is 1 keeps the watchdog inactive after flash mode ends. Only power-on reset re-enables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| wr_stb | input | 1 | Register write strobe, one cycle |
| wr_trig | input | 1 | Trigger bit value carried by the write |
| wr_dis | input | 1 | Disable bit carried by the write (effective in flash mode) |
| flash_mode | input | 1 | Flash-programming mode active |
| vdd_uv | input | 1 | Regulator undervoltage seen |
| wake_evt | input | 1 | Wake event from deepest standby |
| mcu_rst | output | 1 | Reset pulse to the microcontroller, active high |
| gate_kill | output | 1 | Forces the gate drivers off |
| reg_off | output | 1 | Request to switch the regulator off |
| stby_req | output | 1 | Request to enter deepest standby |
| fail_cnt | output | $clog2(STAGE1_FAILS+STAGE2_FAILS+1) | Consecutive failure count |

## Verification
The embedded assertions check several properties on every cycle:
- standby always implies regulator-off;
- no failure is raised while escalation holds the watchdog;
- a service is followed by a cleared counter and a released gate kill;
- every failure is followed by a reset pulse and a gate kill;
- the sticky disable keeps the window logic idle;
- an undervoltage puts the window back at count zero.

Only the bench scenarios can show the timing-dependent behaviour:
- the exact edges at which the early, late and long boundaries fall;
- the pulse width;
- the length of the regulator-off interval;
- the escalation to standby at the fifteenth consecutive failure;
- release by a wake event.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    WD_OFF  = 2'd0,
    WD_LONG = 2'd1,
    WD_WIN  = 2'd2
  } wd_state_e;
endpackage

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int WIDTH_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic out
);
  localparam int PW = $clog2(WIDTH_TICKS + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= PW'(WIDTH_TICKS);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - PW'(1);
    end
  end

  assign out = (cnt_q != '0);

  // R7: a start request reloads the full pulse width
  a_r7_pulse_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == PW'(WIDTH_TICKS)));
endmodule

// File: rtl/wdg_window.sv
module wdg_window
  import wdg_pkg::*;
#(
  parameter int LONG_TICKS  = 6500,
  parameter int EARLY_TICKS = 100,
  parameter int LATE_TICKS  = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_trig,
  input  logic wr_dis,
  input  logic flash_mode,
  input  logic vdd_uv,
  input  logic hold,
  output logic fail_evt,
  output logic svc_ok
);
  localparam int MAXT = (LONG_TICKS > LATE_TICKS) ? LONG_TICKS : LATE_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  wd_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_q, last_d;
  logic          dis_q;
  logic          wd_off, toggle, exit_long;

  assign wd_off    = flash_mode | dis_q;
  assign toggle    = wr_stb & (wr_trig != last_q);
  assign exit_long = wr_stb & wr_trig;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q + CW'(1);
    last_d   = last_q;
    fail_evt = 1'b0;
    svc_ok   = 1'b0;
    if (wd_off) begin
      st_d  = WD_OFF;
      cnt_d = '0;
    end else if (hold || vdd_uv) begin
      st_d  = WD_LONG;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        WD_OFF: begin
          st_d  = WD_LONG;
          cnt_d = '0;
        end
        WD_LONG: begin
          if (exit_long) begin
            st_d   = WD_WIN;
            cnt_d  = '0;
            last_d = 1'b1;
          end else if (cnt_q == CW'(LONG_TICKS - 1)) begin
            fail_evt = 1'b1;
            cnt_d    = '0;
          end
        end
        WD_WIN: begin
          if (toggle) begin
            cnt_d = '0;
            if (cnt_q < CW'(EARLY_TICKS)) begin
              fail_evt = 1'b1;
              st_d     = WD_LONG;
            end else begin
              svc_ok = 1'b1;
              last_d = wr_trig;
            end
          end else if (cnt_q == CW'(LATE_TICKS - 1)) begin
            fail_evt = 1'b1;
            st_d     = WD_LONG;
            cnt_d    = '0;
          end
        end
        default: begin
          st_d  = WD_LONG;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WD_LONG;
      cnt_q  <= '0;
      last_q <= 1'b0;
      dis_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
      if (flash_mode && wr_stb && wr_dis) dis_q <= 1'b1;
    end
  end

  // R12: once the sticky disable is set the window logic stays idle
  a_r12_sticky_idle: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |=> (st_q == WD_OFF));
  // R10: undervoltage returns the window to the start of the long window
  a_r10_uv_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (vdd_uv && !wd_off && !hold) |=> (st_q == WD_LONG && cnt_q == '0));
  // R5: windowed mode never counts past its late boundary
  a_r5_late_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WD_WIN) |-> (cnt_q < CW'(LATE_TICKS)));
endmodule

// File: rtl/wdg_escal.sv
module wdg_escal #(
  parameter int STAGE1_FAILS = 8,
  parameter int STAGE2_FAILS = 7,
  parameter int OFF_TICKS    = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_evt,
  input  logic svc_ok,
  input  logic wake_evt,
  output logic [$clog2(STAGE1_FAILS+STAGE2_FAILS+1)-1:0] fail_cnt,
  output logic reg_off,
  output logic stby_req,
  output logic gate_kill,
  output logic hold
);
  localparam int FW   = $clog2(STAGE1_FAILS + STAGE2_FAILS + 1);
  localparam int OW   = $clog2(OFF_TICKS + 1);
  localparam int LAST = STAGE1_FAILS + STAGE2_FAILS;

  logic [FW-1:0] cnt_q, cnt_nx;
  logic [OW-1:0] off_q;
  logic          off_act_q, stby_q, kill_q;

  assign cnt_nx = cnt_q + FW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      off_q     <= '0;
      off_act_q <= 1'b0;
      stby_q    <= 1'b0;
      kill_q    <= 1'b0;
    end else if (stby_q) begin
      if (wake_evt) begin
        stby_q    <= 1'b0;
        off_act_q <= 1'b0;
        cnt_q     <= '0;
      end
    end else if (off_act_q) begin
      if (off_q == OW'(1)) off_act_q <= 1'b0;
      off_q <= off_q - OW'(1);
    end else if (fail_evt) begin
      cnt_q  <= cnt_nx;
      kill_q <= 1'b1;
      if (cnt_nx == FW'(LAST)) begin
        stby_q    <= 1'b1;
        off_act_q <= 1'b1;
      end else if (cnt_nx == FW'(STAGE1_FAILS)) begin
        off_act_q <= 1'b1;
        off_q     <= OW'(OFF_TICKS);
      end
    end else if (svc_ok) begin
      cnt_q  <= '0;
      kill_q <= 1'b0;
    end
  end

  assign fail_cnt  = cnt_q;
  assign reg_off   = off_act_q;
  assign stby_req  = stby_q;
  assign gate_kill = kill_q;
  assign hold      = off_act_q | stby_q;

  // R9: standby is always accompanied by regulator-off
  a_r9_stby_regoff: assert property (@(posedge clk) disable iff (!rst_n)
    stby_q |-> off_act_q);
  // R8: the window logic raises no failure while escalation holds it
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !fail_evt);
  // R3: a service clears the counter and releases the gate kill
  a_r3_svc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ok && !hold) |=> (cnt_q == '0 && !kill_q));
  // R9: the counter never exceeds the final escalation stage
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FW'(LAST));
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor #(
  parameter int LONG_TICKS   = 6500,
  parameter int EARLY_TICKS  = 100,
  parameter int LATE_TICKS   = 400,
  parameter int PULSE_TICKS  = 16,
  parameter int OFF_TICKS    = 20000,
  parameter int STAGE1_FAILS = 8,
  parameter int STAGE2_FAILS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic wr_trig,
  input  logic wr_dis,
  input  logic flash_mode,
  input  logic vdd_uv,
  input  logic wake_evt,
  output logic mcu_rst,
  output logic gate_kill,
  output logic reg_off,
  output logic stby_req,
  output logic [$clog2(STAGE1_FAILS+STAGE2_FAILS+1)-1:0] fail_cnt
);
  logic fail_evt, svc_ok, hold;

  wdg_window #(
    .LONG_TICKS (LONG_TICKS),
    .EARLY_TICKS(EARLY_TICKS),
    .LATE_TICKS (LATE_TICKS)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_trig   (wr_trig),
    .wr_dis    (wr_dis),
    .flash_mode(flash_mode),
    .vdd_uv    (vdd_uv),
    .hold      (hold),
    .fail_evt  (fail_evt),
    .svc_ok    (svc_ok)
  );

  wdg_escal #(
    .STAGE1_FAILS(STAGE1_FAILS),
    .STAGE2_FAILS(STAGE2_FAILS),
    .OFF_TICKS   (OFF_TICKS)
  ) u_escal (
    .clk      (clk),
    .rst_n    (rst_n),
    .fail_evt (fail_evt),
    .svc_ok   (svc_ok),
    .wake_evt (wake_evt),
    .fail_cnt (fail_cnt),
    .reg_off  (reg_off),
    .stby_req (stby_req),
    .gate_kill(gate_kill),
    .hold     (hold)
  );

  wdg_pulse #(
    .WIDTH_TICKS(PULSE_TICKS)
  ) u_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .start(fail_evt),
    .out  (mcu_rst)
  );

  // R7: every failure is followed by a reset pulse and a gate kill
  a_r7_fail_effects: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> (mcu_rst && gate_kill));
endmodule

// File: tb/wdg_supervisor_bench.sv
module wdg_supervisor_bench;
  localparam int LONG  = 100;
  localparam int EARLY = 10;
  localparam int LATE  = 30;
  localparam int PULSE = 4;
  localparam int OFFT  = 40;
  localparam int FCW   = $clog2(8 + 7 + 1);

  // table: gap before write, trigger value, expected kind (0 service, 1 ignored)
  localparam int NROW = 9;
  localparam int GAP[NROW]  = '{10, 29, 5, 10, 20, 3, 12, 0, 9};
  localparam bit BITV[NROW] = '{1, 0, 0, 1, 1, 0, 1, 1, 0};
  localparam int KIND[NROW] = '{0, 0, 1, 0, 1, 0, 0, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0, wr_trig = 1'b0, wr_dis = 1'b0;
  logic flash_mode = 1'b0, vdd_uv = 1'b0, wake_evt = 1'b0;
  logic mcu_rst, gate_kill, reg_off, stby_req;
  logic [FCW-1:0] fail_cnt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdg_supervisor #(
    .LONG_TICKS(LONG), .EARLY_TICKS(EARLY), .LATE_TICKS(LATE),
    .PULSE_TICKS(PULSE), .OFF_TICKS(OFFT), .STAGE1_FAILS(8), .STAGE2_FAILS(7)
  ) u_wdg_supervisor (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_trig(wr_trig), .wr_dis(wr_dis),
    .flash_mode(flash_mode), .vdd_uv(vdd_uv), .wake_evt(wake_evt),
    .mcu_rst(mcu_rst), .gate_kill(gate_kill), .reg_off(reg_off),
    .stby_req(stby_req), .fail_cnt(fail_cnt)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit b, input bit d);
    wr_trig = b; wr_dis = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; wr_dis = 1'b0;
  endtask

  task automatic fail_once();
    wr(1'b1, 1'b0);
    wr(1'b0, 1'b0);
  endtask

  task automatic por();
    rst_n = 1'b0;
    gap(3);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    por();
    // R1 reset state
    chk(mcu_rst, 0, "R1 mcu_rst");
    chk(gate_kill, 0, "R1 gate_kill");
    chk(reg_off, 0, "R1 reg_off");
    chk(stby_req, 0, "R1 stby_req");
    chk(fail_cnt, 0, "R1 fail_cnt");

    // R2 zero write ignored, long window timeout
    wr(1'b0, 1'b0);
    gap(LONG - 2);
    chk(fail_cnt, 0, "R2 no fail before long bound");
    gap(1);
    chk(fail_cnt, 1, "R2 long timeout counts");
    chk(mcu_rst, 1, "R7 pulse raised");
    chk(gate_kill, 1, "R7 gate kill set");
    gap(PULSE - 1);
    chk(mcu_rst, 1, "R7 pulse still high");
    gap(1);
    chk(mcu_rst, 0, "R7 pulse width ended");

    // R4 early toggle
    wr(1'b1, 1'b0);
    wr(1'b0, 1'b0);
    chk(fail_cnt, 2, "R4 early toggle fails");

    // R3 valid service
    wr(1'b1, 1'b0);
    gap(14);
    wr(1'b0, 1'b0);
    chk(fail_cnt, 0, "R3 service clears count");
    chk(gate_kill, 0, "R3 service clears kill");

    // table walk: R3 services at boundaries, R6 same-value writes
    for (int i = 0; i < NROW; i++) begin
      gap(GAP[i]);
      wr(BITV[i], 1'b0);
      chk(fail_cnt, 0, (KIND[i] == 0) ? "R3 table service" : "R6 table ignored");
      chk(mcu_rst, 0, (KIND[i] == 0) ? "R3 table no pulse" : "R6 table no pulse");
    end

    // R5 late timeout
    gap(LATE - 1);
    chk(fail_cnt, 0, "R5 no fail before late bound");
    gap(1);
    chk(fail_cnt, 1, "R5 late timeout counts");

    // R10 undervoltage restart
    wr(1'b1, 1'b0);
    gap(5);
    vdd_uv = 1'b1;
    gap(1);
    vdd_uv = 1'b0;
    gap(LATE + 10);
    chk(fail_cnt, 1, "R10 no window timeout after uv");
    wr(1'b0, 1'b0);
    gap(LONG - 42);
    chk(fail_cnt, 1, "R10 long window restarted at uv");
    gap(1);
    chk(fail_cnt, 2, "R10 long timeout after uv");
    wr(1'b1, 1'b0);
    gap(12);
    wr(1'b0, 1'b0);
    chk(fail_cnt, 0, "R3 service after uv");

    // R8 first escalation stage
    wr(1'b1, 1'b0);
    for (int k = 0; k < 6; k++) fail_once();
    chk(fail_cnt, 7, "R8 seven failures");
    chk(reg_off, 0, "R8 no regulator off yet");
    fail_once();
    chk(fail_cnt, 8, "R8 eighth failure");
    chk(reg_off, 1, "R8 regulator off raised");
    wr(1'b1, 1'b0);
    wr(1'b0, 1'b0);
    gap(OFFT - 3);
    chk(reg_off, 1, "R8 regulator off held");
    chk(fail_cnt, 8, "R8 writes ignored while off");
    gap(1);
    chk(reg_off, 0, "R8 regulator off released");

    // R9 second escalation stage
    for (int k = 0; k < 6; k++) fail_once();
    chk(fail_cnt, 14, "R9 fourteen failures");
    chk(stby_req, 0, "R9 no standby yet");
    fail_once();
    chk(fail_cnt, 15, "R9 fifteenth failure");
    chk(stby_req, 1, "R9 standby requested");
    chk(reg_off, 1, "R9 regulator off with standby");
    gap(2 * OFFT);
    chk(stby_req, 1, "R9 standby persists");
    chk(reg_off, 1, "R9 regulator off persists");
    wake_evt = 1'b1;
    gap(1);
    wake_evt = 1'b0;
    chk(stby_req, 0, "R9 wake clears standby");
    chk(reg_off, 0, "R9 wake clears regulator off");
    chk(fail_cnt, 0, "R9 wake clears count");
    wr(1'b1, 1'b0);
    gap(12);
    wr(1'b0, 1'b0);
    chk(fail_cnt, 0, "R9 long window after wake");

    // R11 flash mode
    flash_mode = 1'b1;
    gap(LONG + 20);
    chk(fail_cnt, 0, "R11 no failure in flash");
    flash_mode = 1'b0;
    gap(LONG);
    chk(fail_cnt, 0, "R11 long window after flash");
    gap(1);
    chk(fail_cnt, 1, "R11 long timeout after flash");

    // R12 sticky disable
    flash_mode = 1'b1;
    wr(1'b0, 1'b1);
    flash_mode = 1'b0;
    gap(2 * LONG);
    chk(fail_cnt, 1, "R12 stays disabled");
    chk(mcu_rst, 0, "R12 no pulse while disabled");
    por();
    chk(fail_cnt, 0, "R1 count after por");
    gap(LONG - 1);
    chk(fail_cnt, 0, "R12 enabled after por no early fail");
    gap(1);
    chk(fail_cnt, 1, "R12 enabled after por");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule